// File: doc/BRIEF.md
# Prescaled Watchdog Timer

The block is a down-counting watchdog driven by the peripheral clock through two division stages. An 8-bit prescaler divides the clock by (prescaler value + 1). A second stage then divides by 16, 32, 64 or 128. Each output of the second stage is one counter tick, which moves the watchdog count one step toward zero.

Software sets the block up through three word registers on a simple single-cycle bus: a control word, a reload value and the live count. When the count expires, the block reloads it from the reload register. Depending on two enable bits, it also raises a one-cycle interrupt pulse and a fixed-length reset pulse toward the system reset logic. Clearing the run bit freezes the count, so the same block also works as an elapsed-time counter.

Register select on `bus_addr`: 0 is control, 1 is reload value, 2 is count, and 3 reads as zero. Control word layout:
- bits 15:8 prescaler value
- bit 5 run enable
- bits 4:3 division select
- bit 2 interrupt enable
- bit 0 reset enable

All other control bits read as zero.

Top module: `wdp_top`

## Requirements
- R1: After reset the control word reads 0x0000, the reload value and the count both read 0xFFFF, and both pulse outputs are low.
- R2: While running, the count changes exactly every (P+1)×F clock edges, where P is control bits 15:8 and F is the division factor. The first change comes (P+1)×F edges after the control write that sets the run bit.
- R3: Division select (control bits 4:3) encodes 00 as F=16, 01 as F=32, 10 as F=64 and 11 as F=128.
- R4: A tick that finds the count at zero is an expiry. The count then loads the reload value, so a loaded value N expires on its (N+1)th tick. When interrupt enable (bit 2) is set, `irq_o` is high for exactly the one cycle after the expiry edge.
- R5: With interrupt enable and reset enable both clear, an expiry still reloads the count, but neither `irq_o` nor `sys_rst_o` rises.
- R6: When reset enable (bit 0) is set, an expiry drives `sys_rst_o` high from that same edge for RST_CYCLES clock cycles (128 by default).
- R7: Clearing the run bit (bit 5) freezes the count at its current value. It also clears both division stages, so a later enable again waits a full (P+1)×F edges before the first tick.
- R8: A write to the count register takes effect on its write edge, even while running, has priority over a coincident tick, and does not restart the division stages.
- R9: The control and reload registers read back what was written, with the unused control bits reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 control, 1 reload, 2 count |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register (combinational) |
| irq_o | output | 1 | One-cycle expiry interrupt pulse |
| sys_rst_o | output | 1 | Expiry reset pulse, RST_CYCLES cycles long |

## Verification
The assertions assume two things about the inputs. The smallest tick period is 16 clock edges, so two expiries are never adjacent. Bus writes are single-cycle strobes with a stable select. The stimulus keeps to this by driving every bus signal on the falling edge and raising the write strobe for exactly one edge. It also always disables the timer before changing the count or reload for a new scenario, so each scenario starts with both division stages cleared and the edge counts the checks rely on are exact.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_RELOAD = 2'd1,
      SEL_COUNT  = 2'd2,
      SEL_NONE   = 2'd3
   } wdp_sel_e;

   // control word field positions
   localparam int CTL_RST_BIT = 0;
   localparam int CTL_IRQ_BIT = 2;
   localparam int CTL_DIV_LSB = 3;
   localparam int CTL_RUN_BIT = 5;
   localparam int CTL_PRE_LSB = 8;

   typedef struct packed {
      logic [7:0] presc;
      logic       run;
      logic [1:0] dsel;
      logic       irq_en;
      logic       rst_en;
   } wdp_ctl_t;

endpackage

// File: rtl/wdp_prescale.sv
module wdp_prescale #(
   parameter int PRESC_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   input  logic [PRESC_W-1:0] presc_i,
   output logic               tick_o
);

   logic [PRESC_W-1:0] cnt_q;

   // >= keeps the stage bounded if the value is lowered mid-count
   assign tick_o = run_i && (cnt_q >= presc_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run_i) cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   // R7: a halted prescaler restarts from zero
   p_pre_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/wdp_divider.sv
module wdp_divider #(
   parameter int SEL_W    = 2,
   parameter int BASE_LOG = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             pre_tick_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);

   localparam int NSEL  = 1 << SEL_W;
   localparam int DIV_W = BASE_LOG + NSEL - 1;

   logic [DIV_W-1:0] div_q;
   logic [NSEL-1:0]  tap;

   // one tap per selectable factor: low bits all ones
   for (genvar s = 0; s < NSEL; s++) begin : g_tap
      assign tap[s] = &div_q[BASE_LOG+s-1:0];
   end

   if (BASE_LOG < 1) begin : g_bad_base
      $error("wdp_divider: BASE_LOG must be at least 1");
   end

   assign tick_o = pre_tick_i && tap[sel_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          div_q <= '0;
      else if (!run_i)     div_q <= '0;
      else if (pre_tick_i) div_q <= div_q + 1'b1;
   end

   // R3: every factor is at least 2, so ticks never come back to back
   p_tick_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);

endmodule

// File: rtl/wdp_counter.sv
module wdp_counter #(
   parameter int           CNT_W    = 16,
   parameter logic [15:0]  CNT_INIT = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             run_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic [CNT_W-1:0] reload_i,
   input  logic             irq_en_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o,
   output logic             irq_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             irq_q;

   assign expire_o = tick_i && (cnt_q == '0) && !wr_i;
   assign cnt_o    = cnt_q;
   assign irq_o    = irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= CNT_W'(CNT_INIT);
      else if (wr_i)     cnt_q <= wdata_i;
      else if (tick_i)   cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= expire_o && irq_en_i;
   end

   // R7: halted and not written, the count holds
   p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !wr_i) |=> $stable(cnt_q));

   // R4: the interrupt is a single-cycle pulse
   p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);

   // R5: no interrupt unless it was enabled
   p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(irq_en_i));

endmodule

// File: rtl/wdp_pulse.sv
module wdp_pulse #(
   parameter int LEN = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic pulse_o
);

   localparam int LW = $clog2(LEN + 1);

   if (LEN < 1) begin : g_bad_len
      $error("wdp_pulse: LEN must be at least 1");
   end

   logic [LW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left_q <= '0;
      else if (fire_i)         left_q <= LW'(LEN);
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign pulse_o = (left_q != '0);

   // R6: the pulse only starts from an expiry with reset enabled
   p_rst_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_o) |-> $past(fire_i));

endmodule

// File: rtl/wdp_top.sv
module wdp_top
   import wdp_pkg::*;
#(
   parameter int          CNT_W      = 16,
   parameter int          PRESC_W    = 8,
   parameter int          SEL_W      = 2,
   parameter int          BASE_LOG   = 4,
   parameter int          RST_CYCLES = 128,
   parameter logic [15:0] INIT_VAL   = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_addr,
   input  logic             bus_we,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   output logic             irq_o,
   output logic             sys_rst_o
);

   if (CNT_W < CTL_PRE_LSB + PRESC_W) begin : g_bad_w
      $error("wdp_top: CNT_W too narrow for the control word");
   end
   if (SEL_W != 2) begin : g_bad_sel
      $error("wdp_top: division select field is two bits wide");
   end

   logic [PRESC_W-1:0] presc_q;
   logic [SEL_W-1:0]   dsel_q;
   logic               run_q, irq_en_q, rst_en_q;
   logic [CNT_W-1:0]   reload_q;
   logic [CNT_W-1:0]   cnt;
   logic               pre_tick, div_tick, expire, irq;
   logic               wr_ctl, wr_rel, wr_cnt;
   logic [CNT_W-1:0]   ctl_word;

   assign wr_ctl = bus_we && (bus_addr == SEL_CTRL);
   assign wr_rel = bus_we && (bus_addr == SEL_RELOAD);
   assign wr_cnt = bus_we && (bus_addr == SEL_COUNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc_q  <= '0;
         dsel_q   <= '0;
         run_q    <= 1'b0;
         irq_en_q <= 1'b0;
         rst_en_q <= 1'b0;
      end else if (wr_ctl) begin
         presc_q  <= bus_wdata[CTL_PRE_LSB +: PRESC_W];
         dsel_q   <= bus_wdata[CTL_DIV_LSB +: SEL_W];
         run_q    <= bus_wdata[CTL_RUN_BIT];
         irq_en_q <= bus_wdata[CTL_IRQ_BIT];
         rst_en_q <= bus_wdata[CTL_RST_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reload_q <= CNT_W'(INIT_VAL);
      else if (wr_rel) reload_q <= bus_wdata;
   end

   always_comb begin
      ctl_word = '0;
      ctl_word[CTL_PRE_LSB +: PRESC_W] = presc_q;
      ctl_word[CTL_DIV_LSB +: SEL_W]   = dsel_q;
      ctl_word[CTL_RUN_BIT]            = run_q;
      ctl_word[CTL_IRQ_BIT]            = irq_en_q;
      ctl_word[CTL_RST_BIT]            = rst_en_q;
   end

   always_comb begin
      unique case (bus_addr)
         SEL_CTRL:   bus_rdata = ctl_word;
         SEL_RELOAD: bus_rdata = reload_q;
         SEL_COUNT:  bus_rdata = cnt;
         default:    bus_rdata = '0;
      endcase
   end

   wdp_prescale #(.PRESC_W(PRESC_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run_i(run_q),
      .presc_i(presc_q), .tick_o(pre_tick));

   wdp_divider #(.SEL_W(SEL_W), .BASE_LOG(BASE_LOG)) u_div (
      .clk(clk), .rst_n(rst_n), .run_i(run_q), .pre_tick_i(pre_tick),
      .sel_i(dsel_q), .tick_o(div_tick));

   wdp_counter #(.CNT_W(CNT_W), .CNT_INIT(INIT_VAL)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(div_tick), .run_i(run_q),
      .wr_i(wr_cnt), .wdata_i(bus_wdata), .reload_i(reload_q),
      .irq_en_i(irq_en_q), .cnt_o(cnt), .expire_o(expire), .irq_o(irq));

   wdp_pulse #(.LEN(RST_CYCLES)) u_rst (
      .clk(clk), .rst_n(rst_n), .fire_i(expire && rst_en_q),
      .pulse_o(sys_rst_o));

   assign irq_o = irq;

   // R4: after an expiry the count holds the reload value that was in force
   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (cnt == $past(reload_q)));

   // R8: a count write lands on its own edge
   p_cnt_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> (cnt == $past(bus_wdata)));

endmodule

// File: tb/wdp_top_tb.sv
`timescale 1ns/1ps
module wdp_top_tb;

   localparam int RST_LEN = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_o, sys_rst_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   wdp_top u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .sys_rst_o(sys_rst_o));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // control word: [15:8] prescaler, [5] run, [4:3] select, [2] irq en, [0] reset en
   function automatic logic [15:0] ctl(input int p, input bit run, input int s,
                                       input bit ie, input bit re);
      return {p[7:0], 2'b00, run, s[1:0], ie, 1'b0, re};
   endfunction

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic adv(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic setup(input logic [15:0] cnt, input logic [15:0] rel);
      wr(2'd0, 16'h0000);
      wr(2'd1, rel);
      wr(2'd2, cnt);
   endtask

   task automatic t_reset();
      logic [15:0] v;
      rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
      rd(2'd1, v); chk("R1 reload", v, 16'hFFFF);
      rd(2'd2, v); chk("R1 count", v, 16'hFFFF);
      chk("R1 irq", irq_o, 0);
      chk("R1 rst", sys_rst_o, 0);
   endtask

   task automatic t_readback();
      logic [15:0] v;
      wr(2'd0, 16'hFFFF);
      rd(2'd0, v); chk("R9 ctrl readback", v, 16'hFF3D);
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'h1234);
      rd(2'd1, v); chk("R9 reload readback", v, 16'h1234);
      rd(2'd3, v); chk("R9 unused select", v, 16'h0000);
   endtask

   task automatic t_select(input int s);
      logic [15:0] v;
      int f;
      f = 16 << s;
      setup(16'd7, 16'hFFFF);
      wr(2'd0, ctl(0, 1, s, 0, 0));
      adv(f - 1);
      rd(2'd2, v); chk($sformatf("R3 sel%0d before tick", s), v, 16'd7);
      adv(1);
      rd(2'd2, v); chk($sformatf("R3 sel%0d on tick", s), v, 16'd6);
   endtask

   task automatic t_prescale();
      logic [15:0] v;
      setup(16'd7, 16'hFFFF);
      wr(2'd0, ctl(2, 1, 1, 0, 0));
      adv(95);
      rd(2'd2, v); chk("R2 presc2 before tick", v, 16'd7);
      adv(1);
      rd(2'd2, v); chk("R2 presc2 first tick", v, 16'd6);
      adv(95);
      rd(2'd2, v); chk("R2 presc2 before second", v, 16'd6);
      adv(1);
      rd(2'd2, v); chk("R2 presc2 second tick", v, 16'd5);
   endtask

   task automatic t_expiry_irq();
      logic [15:0] v;
      setup(16'd2, 16'd5);
      wr(2'd0, ctl(0, 1, 0, 1, 0));
      adv(47);
      chk("R4 irq before expiry", irq_o, 0);
      rd(2'd2, v); chk("R4 count at zero", v, 16'd0);
      adv(1);
      chk("R4 irq on expiry", irq_o, 1);
      rd(2'd2, v); chk("R4 reloaded", v, 16'd5);
      adv(1);
      chk("R4 irq one cycle", irq_o, 0);
      adv(94);
      chk("R4 no early second irq", irq_o, 0);
      adv(1);
      chk("R4 second expiry from reload", irq_o, 1);
   endtask

   task automatic t_silent();
      logic [15:0] v;
      bit seen;
      seen = 0;
      setup(16'd0, 16'd3);
      wr(2'd0, ctl(0, 1, 0, 0, 0));
      for (int i = 0; i < 20; i++) begin
         adv(1);
         if (irq_o || sys_rst_o) seen = 1;
         if (i == 15) begin
            rd(2'd2, v); chk("R5 reload without pulses", v, 16'd3);
         end
      end
      chk("R5 no irq or reset pulse", seen, 0);
   endtask

   task automatic t_reset_pulse();
      int hi;
      setup(16'd0, 16'hFFFF);
      wr(2'd0, ctl(0, 1, 0, 1, 1));
      adv(15);
      chk("R6 reset low before expiry", sys_rst_o, 0);
      adv(1);
      chk("R6 reset high on expiry", sys_rst_o, 1);
      hi = 1;
      for (int i = 0; i < 300 && sys_rst_o; i++) begin
         adv(1);
         if (sys_rst_o) hi++;
      end
      chk("R6 reset pulse length", hi, RST_LEN);
      wr(2'd0, 16'h0000);
   endtask

   task automatic t_freeze();
      logic [15:0] v;
      setup(16'd20, 16'hFFFF);
      wr(2'd0, ctl(0, 1, 0, 0, 0));
      adv(40);
      wr(2'd0, ctl(0, 0, 0, 0, 0));
      rd(2'd2, v); chk("R7 count at stop", v, 16'd18);
      adv(100);
      rd(2'd2, v); chk("R7 count frozen", v, 16'd18);
      wr(2'd0, ctl(0, 1, 0, 0, 0));
      adv(15);
      rd(2'd2, v); chk("R7 full period after restart", v, 16'd18);
      adv(1);
      rd(2'd2, v); chk("R7 tick after restart", v, 16'd17);
   endtask

   task automatic t_live_write();
      logic [15:0] v;
      setup(16'd100, 16'hFFFF);
      wr(2'd0, ctl(0, 1, 0, 0, 0));
      adv(5);
      wr(2'd2, 16'd3);
      rd(2'd2, v); chk("R8 immediate write", v, 16'd3);
      adv(8);
      rd(2'd2, v); chk("R8 before unchanged tick", v, 16'd3);
      adv(1);
      rd(2'd2, v); chk("R8 divider not restarted", v, 16'd2);
      wr(2'd0, 16'h0000);
   endtask

   initial begin
      adv(3);
      rst_n = 1'b1;
      adv(2);
      t_reset();
      t_readback();
      for (int s = 0; s < 4; s++) t_select(s);
      t_prescale();
      t_expiry_irq();
      t_silent();
      t_reset_pulse();
      t_freeze();
      t_live_write();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule